// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the read side of a two-wire serial memory slave. It watches oversampled clock and data lines, finds START and STOP conditions, takes in a slave address byte and answers reads out of a byte-wide memory array through a simple synchronous read port. A persistent address counter always points one past the last byte sent. A read that carries no address therefore continues from where the previous read stopped. A random read first loads the counter through a write-mode preamble of two address bytes and then reads after a repeated START.

Each data byte is followed by a significant ninth clock. A master acknowledge there asks for the next byte, and the address wraps at the top of the 13-bit space. A missing acknowledge, or a STOP inside that clock, ends the transfer. While the write engine reports a nonvolatile cycle in progress, the slave leaves its address unacknowledged, so a master can poll until the array is free. The data line is only ever pulled low through an output enable. It changes only while the clock line is low.

Top module: `serial_mem_rd_slave`

## Requirements
- R1: A START condition (data falling while clock high) at any point restarts address-byte reception, and a STOP condition (data rising while clock high) at any point returns the slave to idle with the data line released.
- R2: The address byte is received MSB first. Bits [7:4] must be 1010, bits [3:1] must equal the DEV_SEL parameter, and bit 0 is the direction (1 = read). On a match the slave pulls the data line low from the clock fall after the eighth bit until the clock fall after the ninth.
- R3: An address byte that does not match is not acknowledged, and the data line stays released until the next START or STOP.
- R4: When wr_busy is high as the eighth address bit ends, the address byte is not acknowledged.
- R5: After acknowledging a read address, the slave shifts out, MSB first, the byte stored at the counter address. It fetches the byte with a one-cycle mem_rd_en pulse and mem_addr, and takes mem_rdata on the following cycle.
- R6: The address counter is 0 after reset. Each byte sent leaves it at that byte's address plus one, wrapping from 8191 to 0.
- R7: A master acknowledge (data low) in the ninth clock after a data byte makes the slave send the byte at the next address.
- R8: No acknowledge in the ninth clock makes the slave release the line and ignore further clocks until START or STOP. The counter is left unchanged.
- R9: In write direction, the first byte after the address gives addr[12:8] in its low five bits (its upper three bits are ignored) and the second byte gives addr[7:0]. Both are acknowledged. The counter takes the address at the end of the second byte, and a read after a repeated START begins there.
- R10: In write direction, bytes after the two address bytes are not acknowledged and leave the counter unchanged.
- R11: A STOP inside the ninth clock of a read ends the read, and the counter keeps the last address sent plus one.
- R12: The data output enable changes only in the cycle after a detected clock falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| mem_addr | output | 13 | Memory read address (counter value) |
| mem_rd_en | output | 1 | Memory read strobe, one cycle |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the strobe |
| wr_busy | input | 1 | Nonvolatile write cycle in progress |

## Verification
The assertions watch, on every cycle, several rules. The data enable moves only after a clock fall, START or STOP. A STOP always frees the line. A refused or busy address never draws an acknowledge, and a missing master acknowledge parks the slave. The read strobe is a single pulse, and the counter never loads and steps at once. Only the bench scenarios can show the values that arrive on the wire. These include the counter carried across transactions, the wrap from the top address, the random-read preload with its ignored upper bits, the effect of a STOP in the ninth clock, and a restart in the middle of a byte.

// File: rtl/rdslv_pkg.sv
package rdslv_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT} slv_state_e;
  typedef enum logic [1:0] {RK_DEV, RK_AHI, RK_ALO, RK_DATA} rx_kind_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;

  // device-type and select-bit comparison of a received address byte
  function automatic logic id_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == TYPE_CODE) && (b[3:1] == sel);
  endfunction

  // order of bytes received in write direction
  function automatic rx_kind_e next_kind(input rx_kind_e k);
    case (k)
      RK_DEV:  return RK_AHI;
      RK_AHI:  return RK_ALO;
      default: return RK_DATA;
    endcase
  endfunction
endpackage

// File: rtl/rdslv_line_cond.sv
module rdslv_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/rdslv_addr_ctr.sv
module rdslv_addr_ctr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= bump(addr);
  end

  // R6: the sequencer never asks for a load and a step together
  assert_single_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step));

  // R6: stepping from the top address lands on zero
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && addr == {AW{1'b1}}) |=> (addr == '0));
endmodule

// File: rtl/rdslv_tx_ser.sv
module rdslv_tx_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       shift,
  input  logic [7:0] din,
  output logic       next_bit
);
  logic [7:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[6:0], 1'b0};
  end

  assign next_bit = sh_q[6];

  assert_no_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/serial_mem_rd_slave.sv
module serial_mem_rd_slave
  import rdslv_pkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter logic [2:0]  DEV_SEL = 3'b000,
  parameter int          STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rdata,
  input  logic              wr_busy
);
  localparam int HI_W = ADDR_W - 8;

  logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt, cond_evt;

  slv_state_e      state_q;
  rx_kind_e        kind_q;
  logic [3:0]      bitcnt_q;
  logic [7:0]      rx_sh_q, txbuf_q;
  logic [HI_W-1:0] ahi_q;
  logic            rw_q, oe_q, macked_q, rd_q, rd_pend_q;

  // named internal events
  logic byte_done, dev_done_evt, dev_match, dev_ok;
  logic tx_load, tx_shift, tx_next, rd_issue, ctr_load, mack_nack;
  logic [ADDR_W-1:0] ctr_addr;

  rdslv_line_cond #(.STAGES(STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign cond_evt     = start_evt | stop_evt;
  assign byte_done    = (state_q == ST_RX) && scl_fall && (bitcnt_q == 4'd8);
  assign dev_done_evt = byte_done && (kind_q == RK_DEV);
  assign dev_match    = id_hit(rx_sh_q, DEV_SEL);
  assign dev_ok       = dev_match && !wr_busy;
  assign ctr_load     = byte_done && (kind_q == RK_ALO);
  assign tx_load      = !cond_evt && scl_fall &&
                        (((state_q == ST_ACK) && (kind_q == RK_DEV) && rw_q) ||
                         ((state_q == ST_MACK) && macked_q));
  assign tx_shift     = !cond_evt && (state_q == ST_TX) && scl_fall && (bitcnt_q != 4'd8);
  assign mack_nack    = !cond_evt && (state_q == ST_MACK) && scl_rise && sda_lvl;
  assign rd_issue     = !cond_evt &&
                        ((dev_done_evt && dev_ok && rx_sh_q[0]) ||
                         ((state_q == ST_MACK) && scl_rise && !sda_lvl));

  rdslv_addr_ctr #(.AW(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load),
    .load_val({ahi_q, rx_sh_q}), .step(tx_load), .addr(ctr_addr)
  );

  rdslv_tx_ser u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift),
    .din(txbuf_q), .next_bit(tx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= RK_DEV;
      bitcnt_q  <= '0;
      rx_sh_q   <= '0;
      txbuf_q   <= '0;
      ahi_q     <= '0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      macked_q  <= 1'b0;
      rd_q      <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_q      <= rd_issue;
      rd_pend_q <= rd_q;
      if (rd_pend_q) txbuf_q <= mem_rdata;

      if (stop_evt) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        macked_q <= 1'b0;
      end else if (start_evt) begin
        state_q  <= ST_RX;
        kind_q   <= RK_DEV;
        bitcnt_q <= '0;
        oe_q     <= 1'b0;
        macked_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise && bitcnt_q != 4'd8) begin
              rx_sh_q  <= {rx_sh_q[6:0], sda_lvl};
              bitcnt_q <= bitcnt_q + 4'd1;
            end
            if (byte_done) begin
              case (kind_q)
                RK_DEV: begin
                  if (dev_ok) begin
                    state_q <= ST_ACK;
                    oe_q    <= 1'b1;
                    rw_q    <= rx_sh_q[0];
                  end else begin
                    state_q <= ST_WAIT;
                  end
                end
                RK_AHI: begin
                  ahi_q   <= rx_sh_q[HI_W-1:0];
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
                RK_ALO: begin
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
                default: state_q <= ST_WAIT;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (tx_load) begin
                state_q <= ST_TX;
                oe_q    <= ~txbuf_q[7];
              end else begin
                state_q <= ST_RX;
                oe_q    <= 1'b0;
                kind_q  <= next_kind(kind_q);
              end
            end
          end
          ST_TX: begin
            if (scl_rise && bitcnt_q != 4'd8) bitcnt_q <= bitcnt_q + 4'd1;
            if (scl_fall) begin
              if (bitcnt_q == 4'd8) begin
                oe_q     <= 1'b0;
                state_q  <= ST_MACK;
                macked_q <= 1'b0;
              end else begin
                oe_q <= ~tx_next;
              end
            end
          end
          ST_MACK: begin
            if (mack_nack) state_q <= ST_WAIT;
            else if (scl_rise) macked_q <= 1'b1;
            if (tx_load) begin
              state_q  <= ST_TX;
              bitcnt_q <= '0;
              oe_q     <= ~txbuf_q[7];
              macked_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign mem_addr  = ctr_addr;
  assign mem_rd_en = rd_q;

  // R12: the line enable moves only after a clock fall or a bus condition
  assert_sda_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_evt || stop_evt));

  // R1: STOP always frees the line
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R3: a foreign address draws no acknowledge
  assert_refuse_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_done_evt && !dev_match |=> !sda_oe);

  // R4: a busy array draws no acknowledge
  assert_refuse_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_done_evt && wr_busy |=> !sda_oe);

  // R8: a missing master acknowledge parks the slave with the line free
  assert_nack_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mack_nack |=> (state_q == ST_WAIT) && !sda_oe);

  // R5: each fetch is a single-cycle strobe
  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R9: the counter is only preloaded in write direction
  assert_load_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_load |-> !rw_q);
endmodule

// File: tb/serial_mem_rd_slave_tb.sv
module serial_mem_rd_slave_tb_top;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        wr_busy = 1'b0;
  logic        sda_oe;
  logic [12:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata = 8'h00;
  logic        sda_line;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_q[$];

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  serial_mem_rd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_rdata), .wr_busy(wr_busy)
  );

  // array contents are a computed pattern
  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) + (a >> 5) + 7);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(int'(mem_addr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; hold(H);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b0; hold(H);
    m_scl = 1'b0; hold(H);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hold(H);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b1; hold(H);
  endtask

  task automatic m_bit(input logic b);
    m_sda = b;    hold(H);
    m_scl = 1'b1; hold(H);
    m_scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    m_sda = 1'b1; hold(H);
    m_scl = 1'b1; hold(H/2);
    acked = !sda_line;
    hold(H/2);
    m_scl = 1'b0;
  endtask

  task automatic rd_bits(output logic [7:0] d);
    m_sda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      hold(H);
      m_scl = 1'b1; hold(H/2);
      d = {d[6:0], sda_line};
      hold(H/2);
      m_scl = 1'b0;
    end
  endtask

  task automatic rd_byte(input bit give_ack);
    logic [7:0] d;
    rd_bits(d);
    rx_q.push_back(d);
    m_sda = give_ack ? 1'b0 : 1'b1; hold(H);
    m_scl = 1'b1; hold(H);
    m_scl = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic addr_phase(input logic [7:0] b, input bit want, input string tag);
    logic a;
    wr_byte(b, a);
    check(a == want, tag, a, want);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (rx_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = rx_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  // R12: line enable may only move while the clock line is low
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe) check(m_scl == 1'b0, "R12", m_scl, 0);
    prev_oe = sda_oe;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    hold(5);
    check(sda_oe == 1'b0, "R1 reset", sda_oe, 0);
    check(mem_rd_en == 1'b0, "R5 reset", mem_rd_en, 0);
    rst_n = 1'b1;
    hold(5);

    // current-address read from reset value (R2, R5, R6)
    m_start(); addr_phase(8'hA1, 1, "R2 read ack");
    expect_byte(pat(0), "R6 reset counter"); rd_byte(0); m_stop();
    check(sda_oe == 1'b0, "R1 stop release", sda_oe, 0);

    // sequential read continues from counter (R7)
    m_start(); addr_phase(8'hA1, 1, "R2");
    expect_byte(pat(1), "R5"); rd_byte(1);
    expect_byte(pat(2), "R7"); rd_byte(1);
    expect_byte(pat(3), "R7"); rd_byte(0); m_stop();

    // random read near the top, upper bits of high byte ignored, wrap (R9, R6)
    m_start(); addr_phase(8'hA0, 1, "R9 write addr ack");
    addr_phase(8'hFF, 1, "R9 high ack");
    addr_phase(8'hFE, 1, "R9 low ack");
    m_start(); addr_phase(8'hA1, 1, "R9 reread ack");
    expect_byte(pat(13'h1FFE), "R9"); rd_byte(1);
    expect_byte(pat(13'h1FFF), "R7"); rd_byte(1);
    expect_byte(pat(0), "R6 wrap"); rd_byte(0); m_stop();

    // foreign select bits and foreign type code (R3)
    m_start(); addr_phase(8'hA3, 0, "R3 select");
    expect_byte(8'hFF, "R3 released"); rd_byte(0); m_stop();
    m_start(); addr_phase(8'hB1, 0, "R3 type"); m_stop();

    // busy polling (R4)
    wr_busy = 1'b1;
    m_start(); addr_phase(8'hA1, 0, "R4 busy"); m_stop();
    wr_busy = 1'b0;
    m_start(); addr_phase(8'hA1, 1, "R4 free");
    expect_byte(pat(1), "R4 counter kept"); rd_byte(0); m_stop();

    // write data after address is refused (R10)
    m_start(); addr_phase(8'hA0, 1, "R10 dev");
    addr_phase(8'h00, 1, "R10 high");
    addr_phase(8'h40, 1, "R10 low");
    addr_phase(8'h55, 0, "R10 data refused"); m_stop();
    m_start(); addr_phase(8'hA1, 1, "R10");
    expect_byte(pat(8'h40), "R10 counter"); rd_byte(0); m_stop();

    // STOP inside ninth clock (R11)
    m_start(); addr_phase(8'hA1, 1, "R11");
    rd_bits(d);
    check(d == pat(8'h41), "R11 byte", d, pat(8'h41));
    m_sda = 1'b0; hold(H);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b1; hold(H);
    check(sda_oe == 1'b0, "R11 released", sda_oe, 0);
    m_start(); addr_phase(8'hA1, 1, "R11");
    expect_byte(pat(8'h42), "R11 next"); rd_byte(0);

    // no stop after NACK: further clocks ignored (R8)
    m_start(); addr_phase(8'hA1, 1, "R8");
    expect_byte(pat(8'h43), "R8"); rd_byte(0);
    expect_byte(8'hFF, "R8 ignored clocks"); rd_byte(0); m_stop();
    m_start(); addr_phase(8'hA1, 1, "R8");
    expect_byte(pat(8'h44), "R8 counter kept"); rd_byte(0); m_stop();

    // START in the middle of a byte restarts reception (R1)
    m_start(); m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
    m_start(); addr_phase(8'hA1, 1, "R1 restart");
    expect_byte(pat(8'h45), "R1"); rd_byte(0); m_stop();

    hold(20);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule